// File: doc/BRIEF.md
# Dual-Issue Pairing Controller

This block sits between decode and execute in an in-order pipeline that can start two instructions per cycle. Each cycle it looks at the two oldest decoded instructions in the instruction window. The older one always sits in slot 0 and the younger one in slot 1. It then decides whether nothing issues, slot 0 issues alone, or both issue as a pair. It tells the instruction queue how many entries to drop. When slot 0 issues alone, the slot-1 instruction moves up to become slot 0 on the next cycle.

Each candidate carries the following information: a functional-unit class, its register use, a count of extra issue cycles for operations that occupy issue for more than one cycle, and a flag for a load that targets the program counter. The scoreboard supplies one stall request per slot. A slot-0 stall means its operands or its unit are not ready. A slot-1 stall means slot 1 could not start in this cycle without waiting. The unit counts (two ALUs, two multipliers, one divider, one load/store unit) are parameters.

Top module: `dual_issue_pair`

## Requirements
- R1: Slot 1 issues only in a cycle in which slot 0 also issues, and the older instruction always takes slot 0. Two instructions that clear every rule below issue together, with deq_cnt = 2.
- R2: A pair is refused when both instructions need the same class and that class has fewer than two units. Class encoding: 0 = ALU, 1 = multiplier, 2 = divider, 3 = load/store. The default unit counts are 2, 2, 1 and 1.
- R3: A pair is refused when slot 0 writes a register that slot 1 reads through an enabled source port, or that slot 1 also writes.
- R4: An instruction with extra-cycle count X holds slot 0 for X+1 consecutive issuing cycles. issue_s0 is high in each of those cycles. It is dequeued, and may pair, only in the last of them.
- R5: A pair is refused whenever either instruction is a load that writes the program counter.
- R6: When the slot-0 stall request is high, nothing issues, deq_cnt is 0, and the issue-cycle progress of slot 0 is held.
- R7: When the slot-1 stall request is high, slot 1 is not paired, because pairing would stall both slots. Slot 0 still issues alone.
- R8: With only slot 0 valid and not stalled, slot 0 issues alone.
- R9: deq_cnt is the number of instructions that leave the window in the cycle: the last issue cycle of slot 0 counts 1, and a paired slot 1 counts 1 more.
- R10: While rst_n is low (synchronous, active low), nothing issues, and the issue-cycle progress is cleared.
- R11: A slot-1 instruction with a nonzero extra-cycle count is not paired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 2 | Slot 0 unit class |
| s0_dst | input | RIDX_W | Slot 0 destination register |
| s0_dst_en | input | 1 | Slot 0 writes s0_dst |
| s0_xcyc | input | XCYC_W | Slot 0 extra issue cycles |
| s0_pc_load | input | 1 | Slot 0 is a load to the program counter |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 2 | Slot 1 unit class |
| s1_src_a | input | RIDX_W | Slot 1 first source register |
| s1_src_a_en | input | 1 | Slot 1 reads s1_src_a |
| s1_src_b | input | RIDX_W | Slot 1 second source register |
| s1_src_b_en | input | 1 | Slot 1 reads s1_src_b |
| s1_dst | input | RIDX_W | Slot 1 destination register |
| s1_dst_en | input | 1 | Slot 1 writes s1_dst |
| s1_xcyc | input | XCYC_W | Slot 1 extra issue cycles |
| s1_pc_load | input | 1 | Slot 1 is a load to the program counter |
| sb_stall_s0 | input | 1 | Scoreboard stall request for slot 0 |
| sb_stall_s1 | input | 1 | Scoreboard stall request for slot 1 |
| issue_s0 | output | 1 | Slot 0 issues (one issue cycle) this cycle |
| issue_s1 | output | 1 | Slot 1 issues paired with slot 0 |
| deq_cnt | output | 2 | Entries to drop from the instruction queue |

## Verification
The bench builds the block with a 4-bit register index and a 2-bit extra-cycle count, and keeps the default unit counts. With only sixteen registers, random pairs collide on registers often enough to exercise the dependency rule many times. The 2-bit count allows slot-0 holds of up to four cycles, which brings stalls in the middle of a hold within reach. A directed program goes first and forces each refusal reason once. A long random program with random stall requests on both slots follows, and its final instruction exercises the single-valid window.

// File: rtl/dip_pkg.sv
// Package: shared encodings for the dual-issue pairing controller.
// Assumes class codes are fixed by decode and are 2 bits wide.
package dip_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_LSU = 2'd3
    } iclass_e;

    localparam int NUM_CLASSES = 4;

endpackage

// File: rtl/dip_unit_check.sv
// Module: dip_unit_check
// Flags when the two candidates together need more units of one class
// than the machine has. Assumes both candidates are valid (the caller
// gates the result) and that each instruction uses a single unit.
module dip_unit_check
    import dip_pkg::*;
#(
    parameter int NUM_ALU = 2,
    parameter int NUM_MUL = 2,
    parameter int NUM_DIV = 1,
    parameter int NUM_LSU = 1
) (
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    output logic       over_limit
);

    localparam int LIMITS [NUM_CLASSES] = '{NUM_ALU, NUM_MUL, NUM_DIV, NUM_LSU};

    logic [NUM_CLASSES-1:0] cls_over;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic [1:0] demand;
        // Count how many of the two candidates want class c.
        always_comb begin
            demand = {1'b0, (cls_a == c[1:0])} + {1'b0, (cls_b == c[1:0])};
        end
        // Compare the demand against the unit count of class c.
        always_comb begin
            cls_over[c] = (int'(demand) > LIMITS[c]);
        end
    end

    // Any class over its limit blocks the pair.
    always_comb begin
        over_limit = |cls_over;
    end

endmodule

// File: rtl/dip_reg_hazard.sv
// Module: dip_reg_hazard
// Detects a register dependency between the older (slot 0) writer and
// the younger (slot 1) candidate: a read after write through either
// source port, or a write after write. Assumes the register index
// widths are equal on both sides.
module dip_reg_hazard #(
    parameter int RIDX_W = 5
) (
    input  logic [RIDX_W-1:0] old_dst,
    input  logic              old_dst_en,
    input  logic [RIDX_W-1:0] yng_src_a,
    input  logic              yng_src_a_en,
    input  logic [RIDX_W-1:0] yng_src_b,
    input  logic              yng_src_b_en,
    input  logic [RIDX_W-1:0] yng_dst,
    input  logic              yng_dst_en,
    output logic              hazard
);

    localparam int NPORTS = 3;

    logic [RIDX_W-1:0] port_idx [NPORTS];
    logic [NPORTS-1:0] port_en;
    logic [NPORTS-1:0] port_hit;

    // Gather the younger instruction's register ports into one list.
    always_comb begin
        port_idx[0] = yng_src_a;
        port_idx[1] = yng_src_b;
        port_idx[2] = yng_dst;
        port_en     = {yng_dst_en, yng_src_b_en, yng_src_a_en};
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        // A used port that names the older destination is a conflict.
        always_comb begin
            port_hit[p] = old_dst_en && port_en[p] && (port_idx[p] == old_dst);
        end
    end

    // Any conflicting port forbids pairing.
    always_comb begin
        hazard = |port_hit;
    end

endmodule

// File: rtl/dip_cycle_track.sv
// Module: dip_cycle_track
// Tracks how many issue cycles the current slot-0 instruction has
// already spent. Reports when the current cycle is its last one.
// Assumes the window does not change under a slot-0 instruction until
// it is dequeued, and that the extra-cycle count is stable meanwhile.
module dip_cycle_track #(
    parameter int XCYC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [XCYC_W-1:0] xcyc,
    output logic              last_cycle
);

    logic [XCYC_W-1:0] spent_q;

    // The last issue cycle is reached once the spent cycles equal the extra count.
    always_comb begin
        last_cycle = (spent_q == xcyc);
    end

    // Count issue cycles and clear when the instruction leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spent_q <= '0;
        end else if (advance) begin
            if (last_cycle) begin
                spent_q <= '0;
            end else begin
                spent_q <= spent_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_issue_pair.sv
// Module: dual_issue_pair (top)
// Decides, each cycle, whether the two oldest decoded instructions issue
// as a pair, whether slot 0 issues alone, or whether nothing issues. It
// returns the dequeue count to the instruction queue. Assumes the queue
// presents the oldest entry in slot 0 and shifts by deq_cnt each cycle,
// and that the scoreboard has already evaluated the slot-0 sources.
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int RIDX_W  = 5,
    parameter int XCYC_W  = 2,
    parameter int NUM_ALU = 2,
    parameter int NUM_MUL = 2,
    parameter int NUM_DIV = 1,
    parameter int NUM_LSU = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s0_valid,
    input  logic [1:0]        s0_cls,
    input  logic [RIDX_W-1:0] s0_dst,
    input  logic              s0_dst_en,
    input  logic [XCYC_W-1:0] s0_xcyc,
    input  logic              s0_pc_load,
    input  logic              s1_valid,
    input  logic [1:0]        s1_cls,
    input  logic [RIDX_W-1:0] s1_src_a,
    input  logic              s1_src_a_en,
    input  logic [RIDX_W-1:0] s1_src_b,
    input  logic              s1_src_b_en,
    input  logic [RIDX_W-1:0] s1_dst,
    input  logic              s1_dst_en,
    input  logic [XCYC_W-1:0] s1_xcyc,
    input  logic              s1_pc_load,
    input  logic              sb_stall_s0,
    input  logic              sb_stall_s1,
    output logic              issue_s0,
    output logic              issue_s1,
    output logic [1:0]        deq_cnt
);

    logic units_over;
    logic reg_conflict;
    logic s0_last;
    logic s0_go;
    logic pair_ok;

    dip_unit_check #(
        .NUM_ALU (NUM_ALU),
        .NUM_MUL (NUM_MUL),
        .NUM_DIV (NUM_DIV),
        .NUM_LSU (NUM_LSU)
    ) u_units (
        .cls_a      (s0_cls),
        .cls_b      (s1_cls),
        .over_limit (units_over)
    );

    dip_reg_hazard #(
        .RIDX_W (RIDX_W)
    ) u_hazard (
        .old_dst      (s0_dst),
        .old_dst_en   (s0_dst_en),
        .yng_src_a    (s1_src_a),
        .yng_src_a_en (s1_src_a_en),
        .yng_src_b    (s1_src_b),
        .yng_src_b_en (s1_src_b_en),
        .yng_dst      (s1_dst),
        .yng_dst_en   (s1_dst_en),
        .hazard       (reg_conflict)
    );

    dip_cycle_track #(
        .XCYC_W (XCYC_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (s0_go),
        .xcyc       (s0_xcyc),
        .last_cycle (s0_last)
    );

    // Slot 0 advances when out of reset, present and not held by the scoreboard.
    always_comb begin
        s0_go = rst_n && s0_valid && !sb_stall_s0;
    end

    // Slot 1 joins only in slot 0's last cycle and when no pairing rule objects.
    always_comb begin
        pair_ok = s0_last && s1_valid && !sb_stall_s1
               && (s1_xcyc == '0)
               && !s0_pc_load && !s1_pc_load
               && !units_over && !reg_conflict;
    end

    // Drive the issue strobes and the number of entries leaving the window.
    always_comb begin
        issue_s0 = s0_go;
        issue_s1 = s0_go && pair_ok;
        deq_cnt  = {1'b0, s0_go && s0_last} + {1'b0, issue_s1};
    end

endmodule

// File: rtl/dip_checker.sv
// Module: dip_checker
// Property checks on the pairing controller, bound to every instance.
// Assumes the port names of dual_issue_pair.
module dip_checker #(
    parameter int RIDX_W = 5,
    parameter int XCYC_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s0_valid,
    input logic [1:0]        s0_cls,
    input logic [RIDX_W-1:0] s0_dst,
    input logic              s0_dst_en,
    input logic              s0_pc_load,
    input logic              s1_valid,
    input logic [1:0]        s1_cls,
    input logic [RIDX_W-1:0] s1_src_a,
    input logic              s1_src_a_en,
    input logic [RIDX_W-1:0] s1_src_b,
    input logic              s1_src_b_en,
    input logic [XCYC_W-1:0] s1_xcyc,
    input logic              s1_pc_load,
    input logic              sb_stall_s0,
    input logic              sb_stall_s1,
    input logic              issue_s0,
    input logic              issue_s1,
    input logic [1:0]        deq_cnt
);

    assert_slot1_needs_slot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_s1 |-> issue_s0);

    // R2: divider and load/store have a single unit each
    assert_single_unit_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_cls == s1_cls && s0_cls[1]) |-> !issue_s1);

    assert_raw_blocks_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_dst_en && ((s1_src_a_en && s1_src_a == s0_dst) ||
                       (s1_src_b_en && s1_src_b == s0_dst))) |-> !issue_s1);

    assert_hold_no_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_s0 && deq_cnt == 2'd0) |-> !issue_s1);

    assert_pc_load_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_pc_load || s1_pc_load) |-> !issue_s1);

    assert_stall_s0_nothing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sb_stall_s0 |-> (!issue_s0 && deq_cnt == 2'd0));

    assert_stall_s1_unpaired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sb_stall_s1 |-> !issue_s1);

    assert_lone_slot_issues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && !s1_valid && !sb_stall_s0) |-> (issue_s0 && !issue_s1));

    assert_deq_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_cnt == 2'd2) |-> issue_s1);

    assert_deq_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deq_cnt != 2'd3);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |-> (!issue_s0 && !issue_s1 && deq_cnt == 2'd0));

    assert_multi_slot1_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_xcyc != '0) |-> !issue_s1);

endmodule

bind dual_issue_pair dip_checker #(
    .RIDX_W (RIDX_W),
    .XCYC_W (XCYC_W)
) u_dip_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .s0_valid    (s0_valid),
    .s0_cls      (s0_cls),
    .s0_dst      (s0_dst),
    .s0_dst_en   (s0_dst_en),
    .s0_pc_load  (s0_pc_load),
    .s1_valid    (s1_valid),
    .s1_cls      (s1_cls),
    .s1_src_a    (s1_src_a),
    .s1_src_a_en (s1_src_a_en),
    .s1_src_b    (s1_src_b),
    .s1_src_b_en (s1_src_b_en),
    .s1_xcyc     (s1_xcyc),
    .s1_pc_load  (s1_pc_load),
    .sb_stall_s0 (sb_stall_s0),
    .sb_stall_s1 (sb_stall_s1),
    .issue_s0    (issue_s0),
    .issue_s1    (issue_s1),
    .deq_cnt     (deq_cnt)
);

// File: tb/test_dual_issue_pair.sv
// Bench: a program queue and a behavioural cycle model, compared every cycle.
module test_dual_issue_pair;

    localparam int RW   = 4;
    localparam int XW   = 2;
    localparam int MAXP = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s0_valid, s0_dst_en, s0_pc_load;
    logic [1:0]    s0_cls;
    logic [RW-1:0] s0_dst;
    logic [XW-1:0] s0_xcyc;
    logic          s1_valid, s1_src_a_en, s1_src_b_en, s1_dst_en, s1_pc_load;
    logic [1:0]    s1_cls;
    logic [RW-1:0] s1_src_a, s1_src_b, s1_dst;
    logic [XW-1:0] s1_xcyc;
    logic          sb_stall_s0, sb_stall_s1;
    logic          issue_s0, issue_s1;
    logic [1:0]    deq_cnt;

    always #4 clk = ~clk;

    dual_issue_pair #(.RIDX_W(RW), .XCYC_W(XW)) i_dual_issue_pair (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_dst_en(s0_dst_en),
        .s0_xcyc(s0_xcyc), .s0_pc_load(s0_pc_load),
        .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_src_a(s1_src_a), .s1_src_a_en(s1_src_a_en),
        .s1_src_b(s1_src_b), .s1_src_b_en(s1_src_b_en), .s1_dst(s1_dst), .s1_dst_en(s1_dst_en),
        .s1_xcyc(s1_xcyc), .s1_pc_load(s1_pc_load),
        .sb_stall_s0(sb_stall_s0), .sb_stall_s1(sb_stall_s1),
        .issue_s0(issue_s0), .issue_s1(issue_s1), .deq_cnt(deq_cnt)
    );

    // program store
    int p_cls [MAXP];
    int p_sa [MAXP], p_sb [MAXP], p_d [MAXP];
    bit p_sae [MAXP], p_sbe [MAXP], p_de [MAXP], p_pc [MAXP];
    int p_x [MAXP];
    int plen = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int unit_lim [4] = '{2, 2, 1, 1};

    task automatic add(input int cls, input int sa, input bit sae, input int sb, input bit sbe,
                       input int d, input bit de, input int x, input bit pc);
        p_cls[plen] = cls; p_sa[plen] = sa; p_sae[plen] = sae; p_sb[plen] = sb;
        p_sbe[plen] = sbe; p_d[plen] = d; p_de[plen] = de; p_x[plen] = x; p_pc[plen] = pc;
        plen++;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic present(input int h, input bit st0, input bit st1);
        s0_valid = (h < plen);
        s1_valid = (h + 1 < plen);
        s0_cls = (h < plen) ? p_cls[h][1:0] : 2'd0;
        s0_dst = (h < plen) ? p_d[h][RW-1:0] : '0;
        s0_dst_en = (h < plen) ? p_de[h] : 1'b0;
        s0_xcyc = (h < plen) ? p_x[h][XW-1:0] : '0;
        s0_pc_load = (h < plen) ? p_pc[h] : 1'b0;
        s1_cls = (h + 1 < plen) ? p_cls[h+1][1:0] : 2'd0;
        s1_src_a = (h + 1 < plen) ? p_sa[h+1][RW-1:0] : '0;
        s1_src_a_en = (h + 1 < plen) ? p_sae[h+1] : 1'b0;
        s1_src_b = (h + 1 < plen) ? p_sb[h+1][RW-1:0] : '0;
        s1_src_b_en = (h + 1 < plen) ? p_sbe[h+1] : 1'b0;
        s1_dst = (h + 1 < plen) ? p_d[h+1][RW-1:0] : '0;
        s1_dst_en = (h + 1 < plen) ? p_de[h+1] : 1'b0;
        s1_xcyc = (h + 1 < plen) ? p_x[h+1][XW-1:0] : '0;
        s1_pc_load = (h + 1 < plen) ? p_pc[h+1] : 1'b0;
        sb_stall_s0 = st0;
        sb_stall_s1 = st1;
    endtask

    initial begin
        int head;
        int spent;
        int cyc;
        // directed program: each refusal reason in turn
        add(0, 0, 0, 0, 0, 1, 1, 0, 0);  add(0, 2, 1, 5, 1, 6, 1, 0, 0);  // R1 pair
        add(2, 0, 0, 0, 0, 7, 1, 0, 0);  add(2, 1, 1, 0, 0, 8, 1, 0, 0);  // R2 div+div
        add(3, 0, 0, 0, 0, 9, 1, 0, 0);  add(3, 2, 1, 0, 0, 10, 1, 0, 0); // R2 lsu+lsu
        add(1, 0, 0, 0, 0, 11, 1, 0, 0); add(1, 2, 1, 0, 0, 12, 1, 0, 0); // R1 mul+mul
        add(0, 0, 0, 0, 0, 3, 1, 0, 0);  add(0, 0, 0, 3, 1, 13, 1, 0, 0); // R3 raw
        add(0, 0, 0, 0, 0, 4, 1, 0, 0);  add(0, 1, 1, 0, 0, 4, 1, 0, 0);  // R3 waw
        add(1, 0, 0, 0, 0, 14, 1, 2, 0); add(0, 1, 1, 0, 0, 15, 1, 0, 0); // R4 hold
        add(3, 0, 0, 0, 0, 0, 0, 0, 1);  add(0, 1, 1, 0, 0, 2, 1, 0, 0);  // R5
        add(0, 0, 0, 0, 0, 5, 1, 0, 0);  add(3, 1, 1, 0, 0, 0, 0, 0, 1);  // R5
        add(0, 0, 0, 0, 0, 6, 1, 0, 0);  add(1, 1, 1, 0, 0, 7, 1, 1, 0);  // R11
        add(0, 0, 0, 0, 0, 8, 1, 0, 0);
        // random tail
        void'($urandom(32'd7));
        while (plen < 420) begin
            int x;
            x = ($urandom_range(3) == 0) ? int'($urandom_range(3, 1)) : 0;
            add(int'($urandom_range(3)), int'($urandom_range(15)), 1'($urandom_range(1)),
                int'($urandom_range(15)), 1'($urandom_range(1)), int'($urandom_range(15)),
                1'($urandom_range(1)), x, ($urandom_range(9) == 0));
        end

        // reset: a multi-cycle op is already presented (R10)
        head = 0;
        spent = 0;
        present(12, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check("R10", "issue_s0 in reset", int'(issue_s0), 0);
            check("R10", "deq_cnt in reset", int'(deq_cnt), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        cyc = 0;
        while (head < plen + 2) begin
            bit st0, st1, v0, v1, last, pair;
            bit res, haz;
            int e0, e1, ed;
            string tag;
            st0 = (cyc >= 40) && ($urandom_range(4) == 0);
            st1 = (cyc >= 40) && ($urandom_range(3) == 0);
            present(head, st0, st1);
            #1;
            v0 = head < plen;
            v1 = head + 1 < plen;
            last = v0 && (spent == p_x[head]);
            res = v1 && (p_cls[head] == p_cls[head+1]) && (unit_lim[p_cls[head]] < 2);
            haz = v1 && p_de[head] &&
                  ((p_sae[head+1] && p_sa[head+1] == p_d[head]) ||
                   (p_sbe[head+1] && p_sb[head+1] == p_d[head]) ||
                   (p_de[head+1] && p_d[head+1] == p_d[head]));
            pair = 0;
            if (!v0)                          tag = "R8";
            else if (st0)                     tag = "R6";
            else if (!v1)                     tag = "R8";
            else if (!last)                   tag = "R4";
            else if (st1)                     tag = "R7";
            else if (p_x[head+1] != 0)        tag = "R11";
            else if (p_pc[head] || p_pc[head+1]) tag = "R5";
            else if (res)                     tag = "R2";
            else if (haz)                     tag = "R3";
            else begin
                tag = "R1";
                pair = 1;
            end
            e0 = (v0 && !st0) ? 1 : 0;
            e1 = (e0 == 1 && pair) ? 1 : 0;
            ed = ((e0 == 1 && last) ? 1 : 0) + e1;
            check(tag, "issue_s0", int'(issue_s0), e0);
            check(tag, "issue_s1", int'(issue_s1), e1);
            check("R9", "deq_cnt", int'(deq_cnt), ed);
            if (e0 == 1) spent = last ? 0 : spent + 1;
            head += (ed == 0 && !v0) ? 1 : ed;  // past the end, step to leave
            cyc++;
            @(negedge clk);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule